// File: doc/BRIEF.md
# Bi-phase Forward Frame Receiver

This block sits on the slave side of a two-wire lighting control bus and turns the bi-phase (Manchester) coded serial line back into the two payload bytes of a forward frame. It runs from the system clock, which is much faster than the line's bit rate. It brings the line in through a two-flop synchroniser and measures how long each level lasts between edges. A small state machine then decides, edge by edge, whether each edge falls on a bit boundary or in the middle of a bit. A mid-bit edge carries one data bit.

A frame is accepted only when the start bit, all sixteen payload bits and the high stop period are well formed and every level lasts the expected time within the tolerance. The address and data bytes then appear with a one-cycle valid strobe. Any coding violation throws the frame away and gives a one-cycle error strobe. The receiver then goes straight back to looking for the next start bit. Commands and replies are handled elsewhere.

The state machine has six states:
- `ST_HUNT` waits for a falling edge on the line.
- `ST_START` times the first half of the start bit.
- `ST_MID` means the last edge was mid-bit.
- `ST_BOUND` means the last edge was on a bit boundary.
- `ST_STOP_LO` times the second half of a final '0' bit.
- `ST_STOP_HI` times the idle stop period.

Its transitions are:
- `ST_HUNT` moves to `ST_START` on a falling edge.
- `ST_START` moves to `ST_MID` on a rise after a half-length low.
- `ST_MID` moves to `ST_BOUND` on a half-length run, or stays in `ST_MID` and takes a bit on a double-length run.
- `ST_BOUND` moves to `ST_MID` and takes a bit on a half-length run.
- After the sixteenth bit, the machine moves to `ST_STOP_HI` if that bit was '1', or to `ST_STOP_LO` if it was '0'.
- `ST_STOP_LO` moves to `ST_STOP_HI` on a half-length rise.
- `ST_STOP_HI` returns to `ST_HUNT` with valid once the stop time has elapsed.
- Every violation returns the machine to `ST_HUNT` with error.

Top module: `biphase_fwd_rx`

## Requirements
- R1: After reset `valid_o` and `err_o` are 0 and `addr_o` and `data_o` are all zeros.
- R2: The line idles high. A '1' bit is low for its first half and high for its second half, and a '0' bit is high and then low. A frame begins with a falling edge from idle, and its first bit is a '1'.
- R3: The 16 bits after the start bit are taken most-significant first. The first 8 go to `addr_o` and the next 8 go to `data_o`.
- R4: `valid_o` is a one-cycle pulse. It is raised only after the line has stayed high for the stop period, at least STOP_HALVES*LO cycles after the last bit boundary. `addr_o` and `data_o` change only together with `valid_o` and hold their values until the next one.
- R5: With H = HALF_CYC and T = TOL_PCT, LO = floor(H*(100-T)/100) and HI = floor(H*(100+T)/100). A single run of LO..HI cycles and a double run of 2*LO..2*HI cycles are accepted. With H=20 the accepted half-bit lengths are 18 to 22.
- R6: A run shorter than LO, or one that falls between or beyond the accepted ranges, is a code violation. It raises `err_o` and no `valid_o` is given for that frame.
- R7: A missing mid-bit transition, where the level is held past 2*HI cycles, is a violation.
- R8: A double-length run is accepted only when it starts at a mid-bit edge. A double-length run that starts at a bit boundary is a violation.
- R9: A falling edge before the stop period has elapsed is a violation, and the frame is dropped.
- R10: After a violation the receiver accepts the very next well-formed frame without any extra idle time.
- R11: `err_o` is a one-cycle pulse and is never high in the same cycle as `valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| addr_o | output | ADDR_W | Address byte of the last accepted frame |
| data_o | output | DATA_W | Data byte of the last accepted frame |
| valid_o | output | 1 | One-cycle strobe for an accepted frame |
| err_o | output | 1 | One-cycle strobe for a discarded frame |

## Verification
The assertions assume that `rx_i` reaches the receiver only through the synchroniser. They also assume that the line is high whenever no frame is in progress, so that reset and idle leave the machine in `ST_HUNT` with nothing pending.

The bench drives every level for an exact whole number of clock cycles at the falling clock edge. It keeps at least eight half-bits of idle high between frames. A damaged frame therefore always settles, through an error or the hunt state, before the next stimulus begins.

// File: rtl/bprx_pkg.sv
package bprx_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_MID,
        ST_BOUND,
        ST_STOP_LO,
        ST_STOP_HI
    } bprx_state_e;

    typedef enum logic [1:0] {
        RUN_BAD,
        RUN_SHORT,
        RUN_LONG
    } run_class_e;

endpackage

// File: rtl/bprx_sync.sv
module bprx_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic line_o,
    output logic rise_o,
    output logic fall_o
);

    logic meta_q;
    logic sync_q;
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign line_o = sync_q;
    assign rise_o = sync_q & ~prev_q;
    assign fall_o = ~sync_q & prev_q;

endmodule

// File: rtl/bprx_runtimer.sv
module bprx_runtimer
    import bprx_pkg::*;
#(
    parameter int HALF_CYC    = 3333,
    parameter int TOL_PCT     = 10,
    parameter int STOP_HALVES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       edge_i,
    output run_class_e cls_o,
    output logic       over_one_o,
    output logic       over_two_o,
    output logic       stop_bnd_ok_o,
    output logic       stop_mid_ok_o
);

    localparam int LO      = (HALF_CYC * (100 - TOL_PCT)) / 100;
    localparam int HI      = (HALF_CYC * (100 + TOL_PCT)) / 100;
    localparam int LO2     = 2 * LO;
    localparam int HI2     = 2 * HI;
    localparam int STOP_B  = STOP_HALVES * LO - 1;
    localparam int STOP_M  = (STOP_HALVES + 1) * LO - 1;
    localparam int CNT_MAX = HI2 + STOP_M + 1;
    localparam int CW      = $clog2(CNT_MAX + 1);

    localparam logic [CW-1:0] LO_C   = CW'(LO);
    localparam logic [CW-1:0] HI_C   = CW'(HI);
    localparam logic [CW-1:0] LO2_C  = CW'(LO2);
    localparam logic [CW-1:0] HI2_C  = CW'(HI2);
    localparam logic [CW-1:0] STB_C  = CW'(STOP_B);
    localparam logic [CW-1:0] STM_C  = CW'(STOP_M);
    localparam logic [CW-1:0] MAX_C  = CW'(CNT_MAX);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CW'(1);
        end else if (edge_i) begin
            cnt_q <= CW'(1);
        end else if (cnt_q != MAX_C) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    always_comb begin
        if (cnt_q >= LO_C && cnt_q <= HI_C) begin
            cls_o = RUN_SHORT;
        end else if (cnt_q >= LO2_C && cnt_q <= HI2_C) begin
            cls_o = RUN_LONG;
        end else begin
            cls_o = RUN_BAD;
        end
    end

    assign over_one_o    = (cnt_q >= HI_C);
    assign over_two_o    = (cnt_q >= HI2_C);
    assign stop_bnd_ok_o = (cnt_q >= STB_C);
    assign stop_mid_ok_o = (cnt_q >= STM_C);

endmodule

// File: rtl/biphase_fwd_rx.sv
module biphase_fwd_rx
    import bprx_pkg::*;
#(
    parameter int HALF_CYC    = 3333,
    parameter int TOL_PCT     = 10,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int STOP_HALVES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              err_o
);

    localparam int NBITS = ADDR_W + DATA_W;
    localparam int BW    = $clog2(NBITS + 1);
    localparam logic [BW-1:0] LAST_C = BW'(NBITS - 1);

    logic        line;
    logic        rise;
    logic        fall;
    logic        edge_seen;
    run_class_e  cls;
    logic        over_one;
    logic        over_two;
    logic        stop_bnd_ok;
    logic        stop_mid_ok;

    bprx_state_e state_q;
    bprx_state_e state_d;
    logic [NBITS-1:0] shreg_q;
    logic [BW-1:0]    bit_cnt_q;
    logic             from_mid_q;

    logic take_bit;
    logic bit_val;
    logic start_ok;
    logic viol;
    logic done;
    logic set_mid;
    logic clr_mid;

    bprx_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (rx_i),
        .line_o (line),
        .rise_o (rise),
        .fall_o (fall)
    );

    assign edge_seen = rise | fall;

    bprx_runtimer #(
        .HALF_CYC    (HALF_CYC),
        .TOL_PCT     (TOL_PCT),
        .STOP_HALVES (STOP_HALVES)
    ) u_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .edge_i        (edge_seen),
        .cls_o         (cls),
        .over_one_o    (over_one),
        .over_two_o    (over_two),
        .stop_bnd_ok_o (stop_bnd_ok),
        .stop_mid_ok_o (stop_mid_ok)
    );

    // Next-state and decode decisions
    always_comb begin
        state_d  = state_q;
        take_bit = 1'b0;
        bit_val  = rise;
        start_ok = 1'b0;
        viol     = 1'b0;
        done     = 1'b0;
        set_mid  = 1'b0;
        clr_mid  = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                if (fall) state_d = ST_START;
            end
            ST_START: begin
                if (edge_seen) begin
                    if (rise && cls == RUN_SHORT) begin
                        state_d  = ST_MID;
                        start_ok = 1'b1;
                    end else begin
                        viol = 1'b1;
                    end
                end else if (over_one) begin
                    viol = 1'b1;
                end
            end
            ST_MID: begin
                if (edge_seen) begin
                    if (cls == RUN_SHORT) begin
                        state_d = ST_BOUND;
                    end else if (cls == RUN_LONG) begin
                        take_bit = 1'b1;
                        state_d  = ST_MID;
                    end else begin
                        viol = 1'b1;
                    end
                end else if (over_two) begin
                    viol = 1'b1;
                end
            end
            ST_BOUND: begin
                if (edge_seen) begin
                    if (cls == RUN_SHORT) begin
                        take_bit = 1'b1;
                        state_d  = ST_MID;
                    end else begin
                        viol = 1'b1;
                    end
                end else if (over_one) begin
                    viol = 1'b1;
                end
            end
            ST_STOP_LO: begin
                if (edge_seen) begin
                    if (rise && cls == RUN_SHORT) begin
                        state_d = ST_STOP_HI;
                        clr_mid = 1'b1;
                    end else begin
                        viol = 1'b1;
                    end
                end else if (over_one) begin
                    viol = 1'b1;
                end
            end
            ST_STOP_HI: begin
                if (edge_seen) begin
                    viol = 1'b1;
                end else if (from_mid_q ? stop_mid_ok : stop_bnd_ok) begin
                    done    = 1'b1;
                    state_d = ST_HUNT;
                end
            end
            default: begin
                state_d = ST_HUNT;
            end
        endcase
        if (take_bit && bit_cnt_q == LAST_C) begin
            if (bit_val) begin
                state_d = ST_STOP_HI;
                set_mid = 1'b1;
            end else begin
                state_d = ST_STOP_LO;
            end
        end
        if (viol) state_d = ST_HUNT;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q    <= '0;
            bit_cnt_q  <= '0;
            from_mid_q <= 1'b0;
            addr_o     <= '0;
            data_o     <= '0;
            valid_o    <= 1'b0;
            err_o      <= 1'b0;
        end else begin
            valid_o <= done;
            err_o   <= viol;
            if (start_ok) begin
                bit_cnt_q <= '0;
            end else if (take_bit) begin
                bit_cnt_q <= bit_cnt_q + BW'(1);
                shreg_q   <= {shreg_q[NBITS-2:0], bit_val};
            end
            if (set_mid) begin
                from_mid_q <= 1'b1;
            end else if (clr_mid) begin
                from_mid_q <= 1'b0;
            end
            if (done) begin
                addr_o <= shreg_q[NBITS-1 -: ADDR_W];
                data_o <= shreg_q[DATA_W-1:0];
            end
        end
    end

    // R11
    valid_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && err_o));

    // R11
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

    // R4
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R4
    valid_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(line));

    // R4
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(addr_o) && $stable(data_o)) |-> valid_o);

    // R3
    bitcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt_q <= BW'(NBITS));

endmodule

// File: tb/biphase_fwd_rx_tb.sv
module biphase_fwd_rx_tb;

    localparam int CLK_PERIOD = 10;
    localparam int H          = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic [7:0] addr_o;
    logic [7:0] data_o;
    logic       valid_o;
    logic       err_o;

    int n_checks = 0;
    int n_fail   = 0;
    int n_valid  = 0;
    int n_err    = 0;
    int both_cnt = 0;
    int err_run  = 0;
    int err_run_max = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    biphase_fwd_rx #(
        .HALF_CYC (H),
        .TOL_PCT  (10)
    ) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_i    (rx),
        .addr_o  (addr_o),
        .data_o  (data_o),
        .valid_o (valid_o),
        .err_o   (err_o)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (valid_o) n_valid++;
            if (err_o) n_err++;
            if (valid_o && err_o) both_cnt++;
            if (err_o) begin
                err_run++;
                if (err_run > err_run_max) err_run_max = err_run;
            end else begin
                err_run = 0;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic lvl, input int n);
        rx = lvl;
        repeat (n) @(negedge clk);
    endtask

    // R2: '1' = low then high, '0' = high then low, start bit is a '1'
    task automatic send_bits(input logic [15:0] bits, input int half,
                             input int miss_idx, input bit miss_inv);
        logic prev;
        drive(1'b0, half);
        drive(1'b1, half);
        prev = 1'b1;
        for (int i = 15; i >= 0; i--) begin
            if (i == miss_idx) begin
                prev = miss_inv ? ~prev : prev;
                drive(prev, 2 * half);
            end else begin
                drive(~bits[i], half);
                drive(bits[i], half);
                prev = bits[i];
            end
        end
    endtask

    task automatic good_frame(input logic [7:0] a, input logic [7:0] d,
                              input int half, input string req);
        int v0;
        int e0;
        v0 = n_valid;
        e0 = n_err;
        send_bits({a, d}, half, -1, 1'b0);
        drive(1'b1, 8 * H);
        chk({req, " valid count"}, n_valid - v0, 1);
        chk({req, " err count"}, n_err - e0, 0);
        chk({req, " addr"}, int'(addr_o), int'(a));
        chk({req, " data"}, int'(data_o), int'(d));
    endtask

    task automatic expect_reject(input int v0, input int e0, input string req);
        drive(1'b1, 12 * H);
        chk({req, " no valid"}, n_valid - v0, 0);
        chk({req, " err seen"}, int'(n_err > e0), 1);
    endtask

    initial begin
        int v0;
        int e0;
        logic [7:0] a;
        logic [7:0] d;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state
        chk("R1 valid", int'(valid_o), 0);
        chk("R1 err", int'(err_o), 0);
        chk("R1 addr", int'(addr_o), 0);
        chk("R1 data", int'(data_o), 0);
        drive(1'b1, 4 * H);

        // R2 R3 sweep of payload patterns at nominal timing
        good_frame(8'h00, 8'h00, H, "R3 zeros");
        good_frame(8'hFF, 8'hFF, H, "R3 ones");
        good_frame(8'hAA, 8'h55, H, "R2 alternating");
        good_frame(8'h01, 8'h80, H, "R3 msb first");
        for (int i = 0; i < 20; i++) begin
            a = 8'((i * 37 + 5) & 255);
            d = 8'((i * 91 + 13) ^ (i << 3));
            good_frame(a, d, H, "R3 sweep");
        end

        // R4 outputs hold between frames
        drive(1'b1, 40);
        chk("R4 addr hold", int'(addr_o), int'(d == d ? a : a));
        chk("R4 data hold", int'(data_o), int'(d));

        // R5 tolerance edges accepted
        good_frame(8'hA5, 8'h3C, 18, "R5 lo half");
        good_frame(8'h5A, 8'hC3, 22, "R5 hi half");

        // R6 out of tolerance rejected
        v0 = n_valid; e0 = n_err;
        send_bits(16'h1234, 17, -1, 1'b0);
        expect_reject(v0, e0, "R6 short half");
        v0 = n_valid; e0 = n_err;
        send_bits(16'h4321, 23, -1, 1'b0);
        expect_reject(v0, e0, "R6 long half");

        // R7 missing transition, level held
        v0 = n_valid; e0 = n_err;
        send_bits(16'hC6A3, H, 5, 1'b0);
        expect_reject(v0, e0, "R7 held level idx5");
        v0 = n_valid; e0 = n_err;
        send_bits(16'h39E1, H, 12, 1'b0);
        expect_reject(v0, e0, "R7 held level idx12");

        // R8 double run starting at a boundary
        v0 = n_valid; e0 = n_err;
        send_bits(16'h5F0E, H, 9, 1'b1);
        expect_reject(v0, e0, "R8 boundary long idx9");
        v0 = n_valid; e0 = n_err;
        send_bits(16'h8421, H, 3, 1'b1);
        expect_reject(v0, e0, "R8 boundary long idx3");

        // R9 stop period broken, last bit '1' and last bit '0'
        v0 = n_valid; e0 = n_err;
        send_bits(16'h7781, H, -1, 1'b0);
        drive(1'b1, H);
        drive(1'b0, H);
        expect_reject(v0, e0, "R9 stop d0=1");
        v0 = n_valid; e0 = n_err;
        send_bits(16'h7780, H, -1, 1'b0);
        drive(1'b1, 2 * H);
        drive(1'b0, H);
        expect_reject(v0, e0, "R9 stop d0=0");

        // R10 rearm straight after a glitch
        v0 = n_valid; e0 = n_err;
        drive(1'b0, 5);
        drive(1'b1, 3);
        send_bits(16'h9D2B, H, -1, 1'b0);
        drive(1'b1, 8 * H);
        chk("R10 err count", n_err - e0, 1);
        chk("R10 valid count", n_valid - v0, 1);
        chk("R10 addr", int'(addr_o), 8'h9D);
        chk("R10 data", int'(data_o), 8'h2B);

        // R11 error pulse width and exclusivity
        chk("R11 err width", err_run_max, 1);
        chk("R11 no overlap", both_cnt, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (190000) @(negedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule